// File: doc/BRIEF.md
# PHY Bring-Up and Link-Status Sequencer

This block is a command-driven controller for an Ethernet PHY. It sits in front of the request/response port of an MDIO master and turns one high-level command into the register accesses the command needs. The commands are:

- find the PHY address;
- reset the PHY;
- restart auto-negotiation and wait until it completes;
- read the link state;
- read the negotiated speed and duplex;
- program the advertised abilities;
- switch loopback.

The MDIO bit timing is not handled here. The block only issues single-register read and write requests and consumes their responses.

A host starts a command by holding `cmd_valid` for one cycle while `busy` is low. It then waits for the one-cycle `done` pulse and reads the result outputs. The results stay unchanged until the next command is accepted.

The state machine has these states:

| State | Role |
|---|---|
| IDLE | Waits for a command. |
| PROBE_RD | Scan read of the ID register. |
| RST_WR1, RST_WR2 | The two control-register writes of a reset. |
| AN_RD, AN_WR | Read-modify-write of the control register. |
| AN_POLL | Status-register poll. |
| AN_WAIT | Fixed delay between polls. |
| LINK_RD | Status read. |
| TYPE_RD | Diagnostic read. |
| ADV_RD, ADV_WR | Advertisement read-modify-write. |
| LB_RD, LB_WR, LB_RD2 | Loopback read, write and re-read. |
| DONE | Completion. |

The transitions are:

- IDLE goes to the first state of the accepted command. An undefined command goes straight to DONE.
- Each access state moves on only when `mdio_ack` arrives.
- PROBE_RD loops back to itself while the address is absent and below the upper bound.
- AN_POLL goes to DONE on completion or timeout, and otherwise to AN_WAIT.
- AN_WAIT returns to AN_POLL when its delay expires.
- DONE always returns to IDLE.

Top module: `phy_seq`

## Requirements
- R1: A command is accepted when `cmd_valid` is high in a cycle where `busy` is low. The command is selected by `cmd_op`: 0 probe, 1 reset, 2 auto-negotiate, 3 link state, 4 link type, 5 advertise, 6 loopback. `busy` is high from the next cycle until `done`. `done` is high for exactly one cycle. `cmd_valid` has no effect while `busy` is high.
- R2: Each MDIO access holds `mdio_req` and stable `mdio_wr`, `mdio_phy`, `mdio_reg` and `mdio_wdata` until a one-cycle `mdio_ack`. No request is made while idle.
- R3: Probe reads register 2 at addresses ADDR_MIN, ADDR_MIN+1 and so on, in rising order. It stops at the first address whose value is neither 0x0000 nor 0xFFFF. It reports that address on `phy_addr` with `phy_found` high.
- R4: If no address up to ADDR_MAX qualifies, probe ends after reading ADDR_MAX. It reports `phy_addr` = 255 with `phy_found` low. After reset `phy_addr` is 255.
- R5: Reset writes register 0 with 0x8000 and then writes register 0 with 0x1280, both at `phy_addr[4:0]`.
- R6: Auto-negotiate reads register 0 and writes back the read value OR 0x1200. It then reads register 1 until bit 5 is set.
- R7: Consecutive polls of register 1 are separated by a wait of WAIT_CLKS clocks in AN_WAIT.
- R8: With POLL_LIMIT nonzero, POLL_LIMIT polls that all show bit 5 clear end the command with `an_timeout` high. `an_timeout` is cleared when the next command is accepted.
- R9: Link state reads register 1 and sets `link_up` to its bit 2.
- R10: Link type reads register 0x12. It sets `link_full` to bit 11 and `link_fast` to bit 10.
- R11: Advertise reads register 4 and sets bits 8:5. It clears bits 8 and 7 if `arg_fast` is low, and clears bits 8 and 6 if `arg_full` is low. It writes the result back, and `result_word` shows the written value.
- R12: Loopback reads register 0. It sets bit 14 when `arg_loop` is high and inverts bit 14 when `arg_loop` is low. It writes the value back, reads register 0 again, and puts that second read on `result_word`.
- R13: `cmd_op` = 7 completes with `done` and makes no MDIO access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| arg_fast | input | 1 | Advertise: allow 100 Mb/s |
| arg_full | input | 1 | Advertise: allow full duplex |
| arg_loop | input | 1 | Loopback: 1 sets, 0 inverts bit 14 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mdio_req | output | 1 | Access request to the MDIO master |
| mdio_wr | output | 1 | 1 write, 0 read |
| mdio_phy | output | 5 | PHY address of the access |
| mdio_reg | output | 5 | Register number of the access |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | One-cycle completion of the access |
| mdio_rdata | input | 16 | Read data, valid with `mdio_ack` |
| phy_addr | output | 8 | Discovered address or 255 |
| phy_found | output | 1 | Last probe found a device |
| link_up | output | 1 | Link state |
| link_full | output | 1 | Full duplex |
| link_fast | output | 1 | 100 Mb/s |
| result_word | output | 16 | Last relevant register value |
| an_timeout | output | 1 | Auto-negotiation poll limit reached |

## Verification
The checker assumes that `mdio_ack` only answers a pending request, as a single-cycle pulse, and never arrives while `mdio_req` is low. It also assumes that reset is applied before the first command. The bench's MDIO responder keeps to this. It samples a request only after the previous acknowledge has been withdrawn, and replies after a fixed latency of two cycles. The host tasks pulse `cmd_valid` for one cycle and wait for `done` before issuing the next command, except in the scenario that deliberately strobes commands while busy.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    typedef enum logic [2:0] {
        OP_PROBE   = 3'd0,
        OP_RESET   = 3'd1,
        OP_AUTONEG = 3'd2,
        OP_LINK    = 3'd3,
        OP_TYPE    = 3'd4,
        OP_ADVERT  = 3'd5,
        OP_LOOP    = 3'd6,
        OP_NONE    = 3'd7
    } op_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PROBE_RD,
        S_RST_WR1,
        S_RST_WR2,
        S_AN_RD,
        S_AN_WR,
        S_AN_POLL,
        S_AN_WAIT,
        S_LINK_RD,
        S_TYPE_RD,
        S_ADV_RD,
        S_ADV_WR,
        S_LB_RD,
        S_LB_WR,
        S_LB_RD2,
        S_DONE
    } st_e;

    localparam int DW = 16;

    localparam logic [4:0] RG_CTRL = 5'd0;
    localparam logic [4:0] RG_STAT = 5'd1;
    localparam logic [4:0] RG_ID   = 5'd2;
    localparam logic [4:0] RG_ADV  = 5'd4;
    localparam logic [4:0] RG_DIAG = 5'h12;

    localparam logic [DW-1:0] CTRL_SOFT_RESET = 16'h8000;
    localparam logic [DW-1:0] CTRL_AN_BITS    = 16'h1200;
    localparam logic [DW-1:0] CTRL_BRINGUP    = 16'h1280;
    localparam logic [DW-1:0] CTRL_LOOP_BIT   = 16'h4000;

    localparam int STAT_AN_DONE = 5;
    localparam int STAT_LINK    = 2;
    localparam int DIAG_FULL    = 11;
    localparam int DIAG_FAST    = 10;

    localparam logic [7:0] NO_PHY = 8'hFF;

endpackage

// File: rtl/phy_seq_wait.sv
module phy_seq_wait #(
    parameter int WAIT_CLKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (WAIT_CLKS < 2) ? 1 : $clog2(WAIT_CLKS);
    localparam logic [CW-1:0] LOAD = CW'(WAIT_CLKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= LOAD;
        end else if (!run) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);
endmodule

// File: rtl/phy_seq_modify.sv
module phy_seq_modify
    import phy_seq_pkg::*;
(
    input  logic [DW-1:0] rd_val,
    input  logic          want_fast,
    input  logic          want_full,
    input  logic          loop_on,
    output logic [DW-1:0] an_val,
    output logic [DW-1:0] adv_val,
    output logic [DW-1:0] lb_val
);
    localparam logic [DW-1:0] ABIL_ALL  = 16'h01E0;
    localparam logic [DW-1:0] ABIL_FAST = 16'h0180;
    localparam logic [DW-1:0] ABIL_FULL = 16'h0140;

    always_comb begin
        an_val  = rd_val | CTRL_AN_BITS;
        adv_val = rd_val | ABIL_ALL;
        if (!want_fast) adv_val = adv_val & ~ABIL_FAST;
        if (!want_full) adv_val = adv_val & ~ABIL_FULL;
        lb_val  = loop_on ? (rd_val | CTRL_LOOP_BIT) : (rd_val ^ CTRL_LOOP_BIT);
    end
endmodule

// File: rtl/phy_seq.sv
module phy_seq
    import phy_seq_pkg::*;
#(
    parameter int ADDR_MIN   = 0,
    parameter int ADDR_MAX   = 31,
    parameter int WAIT_CLKS  = 1000,
    parameter int POLL_LIMIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic        arg_fast,
    input  logic        arg_full,
    input  logic        arg_loop,
    output logic        busy,
    output logic        done,
    output logic        mdio_req,
    output logic        mdio_wr,
    output logic [4:0]  mdio_phy,
    output logic [4:0]  mdio_reg,
    output logic [15:0] mdio_wdata,
    input  logic        mdio_ack,
    input  logic [15:0] mdio_rdata,
    output logic [7:0]  phy_addr,
    output logic        phy_found,
    output logic        link_up,
    output logic        link_full,
    output logic        link_fast,
    output logic [15:0] result_word,
    output logic        an_timeout
);
    localparam int PW = (POLL_LIMIT < 2) ? 1 : $clog2(POLL_LIMIT + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'((POLL_LIMIT > 0) ? POLL_LIMIT - 1 : 0);
    localparam logic [4:0] A_LO = 5'(ADDR_MIN);
    localparam logic [4:0] A_HI = 5'(ADDR_MAX);

    st_e           state;
    logic [4:0]    cur_addr;
    logic [PW-1:0] polls;
    logic [DW-1:0] rd_hold;
    logic          a_fast, a_full, a_loop;
    logic          wait_done;
    logic          id_ok;
    logic [DW-1:0] an_val, adv_val, lb_val;

    phy_seq_wait #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_AN_WAIT),
        .expired (wait_done)
    );

    phy_seq_modify u_mod (
        .rd_val    (rd_hold),
        .want_fast (a_fast),
        .want_full (a_full),
        .loop_on   (a_loop),
        .an_val    (an_val),
        .adv_val   (adv_val),
        .lb_val    (lb_val)
    );

    assign id_ok = (mdio_rdata != 16'h0000) && (mdio_rdata != 16'hFFFF);

    // state and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            cur_addr    <= A_LO;
            polls       <= '0;
            rd_hold     <= '0;
            a_fast      <= 1'b0;
            a_full      <= 1'b0;
            a_loop      <= 1'b0;
            phy_addr    <= NO_PHY;
            phy_found   <= 1'b0;
            link_up     <= 1'b0;
            link_full   <= 1'b0;
            link_fast   <= 1'b0;
            result_word <= '0;
            an_timeout  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        a_fast     <= arg_fast;
                        a_full     <= arg_full;
                        a_loop     <= arg_loop;
                        an_timeout <= 1'b0;
                        polls      <= '0;
                        unique case (op_e'(cmd_op))
                            OP_PROBE: begin
                                cur_addr  <= A_LO;
                                phy_found <= 1'b0;
                                state     <= S_PROBE_RD;
                            end
                            OP_RESET:   state <= S_RST_WR1;
                            OP_AUTONEG: state <= S_AN_RD;
                            OP_LINK:    state <= S_LINK_RD;
                            OP_TYPE:    state <= S_TYPE_RD;
                            OP_ADVERT:  state <= S_ADV_RD;
                            OP_LOOP:    state <= S_LB_RD;
                            OP_NONE:    state <= S_DONE;
                        endcase
                    end
                end
                S_PROBE_RD: if (mdio_ack) begin
                    if (id_ok) begin
                        phy_addr  <= {3'b000, cur_addr};
                        phy_found <= 1'b1;
                        state     <= S_DONE;
                    end else if (cur_addr == A_HI) begin
                        phy_addr  <= NO_PHY;
                        state     <= S_DONE;
                    end else begin
                        cur_addr  <= cur_addr + 1'b1;
                    end
                end
                S_RST_WR1: if (mdio_ack) state <= S_RST_WR2;
                S_RST_WR2: if (mdio_ack) state <= S_DONE;
                S_AN_RD: if (mdio_ack) begin
                    rd_hold <= mdio_rdata;
                    state   <= S_AN_WR;
                end
                S_AN_WR: if (mdio_ack) state <= S_AN_POLL;
                S_AN_POLL: if (mdio_ack) begin
                    result_word <= mdio_rdata;
                    if (mdio_rdata[STAT_AN_DONE]) begin
                        state <= S_DONE;
                    end else if ((POLL_LIMIT != 0) && (polls == POLL_LAST)) begin
                        an_timeout <= 1'b1;
                        state      <= S_DONE;
                    end else begin
                        polls <= polls + 1'b1;
                        state <= S_AN_WAIT;
                    end
                end
                S_AN_WAIT: if (wait_done) state <= S_AN_POLL;
                S_LINK_RD: if (mdio_ack) begin
                    link_up     <= mdio_rdata[STAT_LINK];
                    result_word <= mdio_rdata;
                    state       <= S_DONE;
                end
                S_TYPE_RD: if (mdio_ack) begin
                    link_full   <= mdio_rdata[DIAG_FULL];
                    link_fast   <= mdio_rdata[DIAG_FAST];
                    result_word <= mdio_rdata;
                    state       <= S_DONE;
                end
                S_ADV_RD: if (mdio_ack) begin
                    rd_hold <= mdio_rdata;
                    state   <= S_ADV_WR;
                end
                S_ADV_WR: if (mdio_ack) begin
                    result_word <= adv_val;
                    state       <= S_DONE;
                end
                S_LB_RD: if (mdio_ack) begin
                    rd_hold <= mdio_rdata;
                    state   <= S_LB_WR;
                end
                S_LB_WR: if (mdio_ack) state <= S_LB_RD2;
                S_LB_RD2: if (mdio_ack) begin
                    result_word <= mdio_rdata;
                    state       <= S_DONE;
                end
                S_DONE: state <= S_IDLE;
            endcase
        end
    end

    // request and handshake outputs
    always_comb begin
        mdio_req   = 1'b0;
        mdio_wr    = 1'b0;
        mdio_reg   = RG_CTRL;
        mdio_wdata = '0;
        mdio_phy   = (state == S_PROBE_RD) ? cur_addr : phy_addr[4:0];
        busy       = (state != S_IDLE);
        done       = (state == S_DONE);
        unique case (state)
            S_PROBE_RD: begin mdio_req = 1'b1; mdio_reg = RG_ID; end
            S_RST_WR1:  begin mdio_req = 1'b1; mdio_wr = 1'b1; mdio_wdata = CTRL_SOFT_RESET; end
            S_RST_WR2:  begin mdio_req = 1'b1; mdio_wr = 1'b1; mdio_wdata = CTRL_BRINGUP; end
            S_AN_RD:    begin mdio_req = 1'b1; end
            S_AN_WR:    begin mdio_req = 1'b1; mdio_wr = 1'b1; mdio_wdata = an_val; end
            S_AN_POLL:  begin mdio_req = 1'b1; mdio_reg = RG_STAT; end
            S_LINK_RD:  begin mdio_req = 1'b1; mdio_reg = RG_STAT; end
            S_TYPE_RD:  begin mdio_req = 1'b1; mdio_reg = RG_DIAG; end
            S_ADV_RD:   begin mdio_req = 1'b1; mdio_reg = RG_ADV; end
            S_ADV_WR:   begin mdio_req = 1'b1; mdio_wr = 1'b1; mdio_reg = RG_ADV; mdio_wdata = adv_val; end
            S_LB_RD:    begin mdio_req = 1'b1; end
            S_LB_WR:    begin mdio_req = 1'b1; mdio_wr = 1'b1; mdio_wdata = lb_val; end
            S_LB_RD2:   begin mdio_req = 1'b1; end
            S_IDLE, S_AN_WAIT, S_DONE: begin end
        endcase
    end
endmodule

// File: rtl/phy_seq_chk.sv
module phy_seq_chk #(
    parameter int ADDR_MIN = 0,
    parameter int ADDR_MAX = 31
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        busy,
    input logic        done,
    input logic        mdio_req,
    input logic        mdio_wr,
    input logic [4:0]  mdio_phy,
    input logic [4:0]  mdio_reg,
    input logic [15:0] mdio_wdata,
    input logic        mdio_ack,
    input logic [7:0]  phy_addr,
    input logic        phy_found,
    input logic        an_timeout
);
    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_wr) && $stable(mdio_phy)
                                     && $stable(mdio_reg) && $stable(mdio_wdata)));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_req);

    p_found_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phy_found |-> (int'(phy_addr) >= ADDR_MIN && int'(phy_addr) <= ADDR_MAX));

    p_timeout_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_timeout) |-> done);
endmodule

bind phy_seq phy_seq_chk #(.ADDR_MIN(ADDR_MIN), .ADDR_MAX(ADDR_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .done       (done),
    .mdio_req   (mdio_req),
    .mdio_wr    (mdio_wr),
    .mdio_phy   (mdio_phy),
    .mdio_reg   (mdio_reg),
    .mdio_wdata (mdio_wdata),
    .mdio_ack   (mdio_ack),
    .phy_addr   (phy_addr),
    .phy_found  (phy_found),
    .an_timeout (an_timeout)
);

// File: tb/tb_phy_seq.sv
`timescale 1ns/1ps
module tb_phy_seq;
    localparam int AMIN = 2;
    localparam int AMAX = 9;
    localparam int WAITC = 20;
    localparam int PLIM = 4;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        arg_fast = 1'b0, arg_full = 1'b0, arg_loop = 1'b0;
    logic        busy, done, mdio_req, mdio_wr;
    logic [4:0]  mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata;
    logic        mdio_ack = 1'b0;
    logic [15:0] mdio_rdata = 16'h0;
    logic [7:0]  phy_addr;
    logic        phy_found, link_up, link_full, link_fast, an_timeout;
    logic [15:0] result_word;

    phy_seq #(.ADDR_MIN(AMIN), .ADDR_MAX(AMAX), .WAIT_CLKS(WAITC), .POLL_LIMIT(PLIM)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .arg_fast(arg_fast), .arg_full(arg_full), .arg_loop(arg_loop),
        .busy(busy), .done(done), .mdio_req(mdio_req), .mdio_wr(mdio_wr),
        .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
        .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata), .phy_addr(phy_addr),
        .phy_found(phy_found), .link_up(link_up), .link_full(link_full),
        .link_fast(link_fast), .result_word(result_word), .an_timeout(an_timeout)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // MDIO responder model
    logic [15:0] mem [0:31][0:31];
    int an_after = 0;
    int poll_n = 0;
    int nlog = 0;
    logic        lwr [0:63];
    logic [4:0]  lphy [0:63];
    logic [4:0]  lreg [0:63];
    logic [15:0] ldat [0:63];
    int          lcyc [0:63];
    logic        pend = 1'b0;
    int          lat_cnt = 0;
    logic        c_wr;
    logic [4:0]  c_phy, c_reg;
    logic [15:0] c_dat;

    always @(negedge clk) begin
        if (mdio_ack) begin
            mdio_ack = 1'b0;
        end else if (pend) begin
            if (lat_cnt == 0) begin
                if (c_wr) begin
                    mem[c_phy][c_reg] = c_dat;
                end else if (c_reg == 5'd1) begin
                    poll_n++;
                    mdio_rdata = mem[c_phy][1] & ~16'h0020;
                    if (poll_n >= an_after) mdio_rdata = mdio_rdata | 16'h0020;
                end else begin
                    mdio_rdata = mem[c_phy][c_reg];
                end
                mdio_ack = 1'b1;
                pend = 1'b0;
            end else begin
                lat_cnt--;
            end
        end else if (mdio_req && rst_n) begin
            c_wr = mdio_wr; c_phy = mdio_phy; c_reg = mdio_reg; c_dat = mdio_wdata;
            if (nlog < 64) begin
                lwr[nlog] = c_wr; lphy[nlog] = c_phy; lreg[nlog] = c_reg;
                ldat[nlog] = c_dat; lcyc[nlog] = cyc;
            end
            nlog++;
            pend = 1'b1;
            lat_cnt = LAT;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int a = 0; a < 32; a++)
            for (int r = 0; r < 32; r++)
                mem[a][r] = 16'h0000;
    endtask

    task automatic start_cmd(input logic [2:0] op, input logic f, input logic d, input logic lp);
        nlog = 0;
        poll_n = 0;
        @(negedge clk);
        cmd_op = op; arg_fast = f; arg_full = d; arg_loop = lp; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R1 done seen"}, done, 1'b1);
        @(negedge clk);
        chk({tag, " R1 done one cycle"}, done, 1'b0);
    endtask

    task automatic run_cmd(input string tag, input logic [2:0] op,
                           input logic f, input logic d, input logic lp);
        start_cmd(op, f, d, lp);
        wait_done(tag);
    endtask

    task automatic t_reset_state();
        chk("R4 reset phy_addr", phy_addr, 8'hFF);
        chk("R1 reset busy", busy, 1'b0);
        chk("R2 reset no req", mdio_req, 1'b0);
        chk("R8 reset timeout", an_timeout, 1'b0);
    endtask

    task automatic t_probe_found();
        clear_mem();
        mem[1][2] = 16'h2000;
        mem[2][2] = 16'hFFFF;
        mem[5][2] = 16'h2000;
        mem[7][2] = 16'h0181;
        run_cmd("probe", 3'd0, 0, 0, 0);
        chk("R3 found addr", phy_addr, 8'd5);
        chk("R3 found flag", phy_found, 1'b1);
        chk("R3 read count", nlog, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R3 scan addr order", lphy[i], 5'(AMIN + i));
            chk("R3 scan reg", {lwr[i], lreg[i]}, {1'b0, 5'd2});
        end
    endtask

    task automatic t_probe_none();
        clear_mem();
        mem[1][2] = 16'h2000;
        mem[10][2] = 16'h2000;
        mem[4][2] = 16'hFFFF;
        run_cmd("probe none", 3'd0, 0, 0, 0);
        chk("R4 sentinel", phy_addr, 8'hFF);
        chk("R4 not found", phy_found, 1'b0);
        chk("R4 read count", nlog, AMAX - AMIN + 1);
        chk("R4 last addr", lphy[AMAX - AMIN], 5'(AMAX));
    endtask

    task automatic t_phy_reset();
        clear_mem();
        mem[5][2] = 16'h2000;
        run_cmd("probe again", 3'd0, 0, 0, 0);
        run_cmd("reset", 3'd1, 0, 0, 0);
        chk("R5 two writes", nlog, 2);
        chk("R5 first write", {lwr[0], lphy[0], lreg[0], ldat[0]}, {1'b1, 5'd5, 5'd0, 16'h8000});
        chk("R5 second write", {lwr[1], lphy[1], lreg[1], ldat[1]}, {1'b1, 5'd5, 5'd0, 16'h1280});
    endtask

    task automatic t_autoneg();
        mem[5][0] = 16'h0100;
        an_after = 3;
        run_cmd("autoneg", 3'd2, 0, 0, 0);
        chk("R6 access count", nlog, 5);
        chk("R6 read ctrl", {lwr[0], lreg[0]}, {1'b0, 5'd0});
        chk("R6 write ctrl", {lwr[1], lreg[1], ldat[1]}, {1'b1, 5'd0, 16'h1300});
        chk("R6 poll reg", {lwr[2], lreg[2], lwr[4], lreg[4]}, {1'b0, 5'd1, 1'b0, 5'd1});
        chk("R7 poll gap a", lcyc[3] - lcyc[2], WAITC + LAT + 2);
        chk("R7 poll gap b", lcyc[4] - lcyc[3], WAITC + LAT + 2);
        chk("R8 no timeout", an_timeout, 1'b0);
    endtask

    task automatic t_autoneg_timeout();
        an_after = 100;
        run_cmd("an timeout", 3'd2, 0, 0, 0);
        chk("R8 polls at limit", nlog, 2 + PLIM);
        chk("R8 timeout set", an_timeout, 1'b1);
        an_after = 0;
        mem[5][1] = 16'h0004;
        run_cmd("link", 3'd3, 0, 0, 0);
        chk("R8 timeout cleared", an_timeout, 1'b0);
        chk("R9 link up", link_up, 1'b1);
        mem[5][1] = 16'h0000;
        run_cmd("link down", 3'd3, 0, 0, 0);
        chk("R9 link down", link_up, 1'b0);
        chk("R9 reg", lreg[0], 5'd1);
    endtask

    task automatic t_link_type();
        mem[5][5'h12] = 16'h0800;
        run_cmd("type fdx", 3'd4, 0, 0, 0);
        chk("R10 reg", lreg[0], 5'h12);
        chk("R10 full/fast", {link_full, link_fast}, 2'b10);
        mem[5][5'h12] = 16'h0400;
        run_cmd("type fast", 3'd4, 0, 0, 0);
        chk("R10 full/fast b", {link_full, link_fast}, 2'b01);
    endtask

    task automatic adv_case(input logic f, input logic d, input logic [15:0] exp);
        mem[5][4] = 16'h0001;
        run_cmd("advert", 3'd5, f, d, 0);
        chk("R11 write", {lwr[1], lreg[1], ldat[1]}, {1'b1, 5'd4, exp});
        chk("R11 result", result_word, exp);
    endtask

    task automatic t_advert();
        adv_case(1, 1, 16'h01E1);
        adv_case(0, 1, 16'h0061);
        adv_case(1, 0, 16'h00A1);
        adv_case(0, 0, 16'h0021);
    endtask

    task automatic t_loop();
        mem[5][0] = 16'h1000;
        run_cmd("loop on", 3'd6, 0, 0, 1);
        chk("R12 access count", nlog, 3);
        chk("R12 write set", ldat[1], 16'h5000);
        chk("R12 reread", {lwr[2], lreg[2], result_word}, {1'b0, 5'd0, 16'h5000});
        run_cmd("loop off", 3'd6, 0, 0, 0);
        chk("R12 toggle clears", result_word, 16'h1000);
        run_cmd("loop off again", 3'd6, 0, 0, 0);
        chk("R12 toggle sets", result_word, 16'h5000);
    endtask

    task automatic t_busy_ignore();
        an_after = 2;
        mem[5][0] = 16'h0000;
        start_cmd(3'd2, 0, 0, 0);
        chk("R1 busy after accept", busy, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cmd_op = 3'd1; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        wait_done("busy ignore");
        repeat (10) @(negedge clk);
        chk("R1 ignored cmd no access", nlog, 4);
        chk("R1 ignored idle", busy, 1'b0);
    endtask

    task automatic t_bad_op();
        run_cmd("op7", 3'd7, 0, 0, 0);
        chk("R13 no access", nlog, 0);
        chk("R13 addr kept", phy_addr, 8'd5);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_probe_found();
        t_probe_none();
        t_phy_reset();
        t_autoneg();
        t_autoneg_timeout();
        t_link_type();
        t_advert();
        t_loop();
        t_busy_ignore();
        t_bad_op();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule